// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block holds the per-window settings of a display scan-out engine in two copies. Software writes only the pending copy, through a simple write/read port. The active copy feeds the fetch logic. It changes only when the `vsync` pulse marks a frame boundary, so a frame never starts with a mix of old and new settings.

Each window has a buffer start address, a buffer end address, a line offset, a page width, a window enable and a DMA channel enable. Each window also has a protect bit, which acts at once. While the protect bit is set, frame boundaries leave that window's active copy alone. Software can therefore rewrite several fields and release them all together at the first boundary after it clears the bit. Every window that takes a copy reports it with a one-cycle `xfer_done` pulse.

Top module: `shadow_bank`

## Requirements
- R1: After a synchronous reset, every pending field, active field, protect bit, window enable and channel enable is zero, and `xfer_done` is low.
- R2: Register map. `wr_addr[5:3]` selects the window (0..NUM_WIN-1) and `wr_addr[2:0]` selects the field: 0 start address, 1 end address, 2 line offset, 3 page width, 4 control (bit 0 window enable, bit 1 DMA channel enable), 5 protect (bit 0). A write updates the addressed pending field. A read with `rd_active`=0 returns that pending value, zero-extended, on `rd_data` one cycle after the address is presented.
- R3: Active outputs change only on a cycle in which `vsync` is high.
- R4: When `vsync` is high and a window is unprotected, all of that window's active fields take its pending values at that edge, and its `xfer_done` bit is high for exactly that one following cycle.
- R5: When `vsync` is high and a window is protected, its active fields keep their values and its `xfer_done` bit stays low.
- R6: Pending values written while a window was protected are transferred at the first `vsync` after its protect bit is cleared.
- R7: Clearing a window's DMA channel enable leaves `act_chan_en` high until the next `vsync` that transfers that window.
- R8: A write presented in the same cycle as `vsync` lands in pending only. The transfer at that edge uses the older pending value, and the new value moves over at the following `vsync`.
- R9: With `rd_active`=1, a read returns the active copy of the addressed field.
- R10: Writes to a window index of NUM_WIN or above, or to fields 6 and 7, change nothing. Reads of those addresses return zero.
- R11: A protect write presented in the same cycle as `vsync` takes effect after that edge. The protect value held before the edge decides that edge's transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address {window, field} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address {window, field} |
| rd_active | input | 1 | 0 reads pending copy, 1 reads active copy |
| rd_data | output | 32 | Registered read data |
| vsync | input | 1 | Frame-boundary pulse |
| act_start | output | 160 | Active start address, 32 bits per window |
| act_end | output | 160 | Active end address, 32 bits per window |
| act_offs | output | 65 | Active line offset, 13 bits per window |
| act_pgw | output | 65 | Active page width, 13 bits per window |
| act_win_en | output | 5 | Active window enables |
| act_chan_en | output | 5 | Active DMA channel enables |
| xfer_done | output | 5 | Per-window one-cycle transfer pulse |

## Verification
Two things can fall on the same edge: a software write and the frame-boundary transfer. The bench provokes this by presenting a data write together with `vsync` on one window. It also presents a protect write together with `vsync` on another window. It then judges the result from the outputs. The active copy must show the value held before the edge and `xfer_done` must follow the protect state held before the edge. A pending read must show the new value, and the next `vsync` must carry it over.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int FIELD_AW = 3;

  typedef enum logic [FIELD_AW-1:0] {
    FLD_START = 3'd0,
    FLD_END   = 3'd1,
    FLD_OFFS  = 3'd2,
    FLD_PGW   = 3'd3,
    FLD_CTRL  = 3'd4,
    FLD_PROT  = 3'd5
  } field_e;
endpackage

// File: rtl/shadow_win.sv
module shadow_win
  import shadow_bank_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int OW = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [FIELD_AW-1:0] wr_field_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                vsync_i,
  output logic [AW-1:0]       pend_start_o,
  output logic [AW-1:0]       pend_end_o,
  output logic [OW-1:0]       pend_offs_o,
  output logic [OW-1:0]       pend_pgw_o,
  output logic [1:0]          pend_ctrl_o,
  output logic                prot_o,
  output logic [AW-1:0]       act_start_o,
  output logic [AW-1:0]       act_end_o,
  output logic [OW-1:0]       act_offs_o,
  output logic [OW-1:0]       act_pgw_o,
  output logic [1:0]          act_ctrl_o,
  output logic                done_o
);
  logic take;
  assign take = vsync_i && !prot_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_start_o <= '0;
      pend_end_o   <= '0;
      pend_offs_o  <= '0;
      pend_pgw_o   <= '0;
      pend_ctrl_o  <= '0;
      prot_o       <= 1'b0;
      act_start_o  <= '0;
      act_end_o    <= '0;
      act_offs_o   <= '0;
      act_pgw_o    <= '0;
      act_ctrl_o   <= '0;
      done_o       <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_field_i)
          FLD_START: pend_start_o <= wr_data_i[AW-1:0];
          FLD_END:   pend_end_o   <= wr_data_i[AW-1:0];
          FLD_OFFS:  pend_offs_o  <= wr_data_i[OW-1:0];
          FLD_PGW:   pend_pgw_o   <= wr_data_i[OW-1:0];
          FLD_CTRL:  pend_ctrl_o  <= wr_data_i[1:0];
          FLD_PROT:  prot_o       <= wr_data_i[0];
          default: ;
        endcase
      end
      done_o <= take;
      if (take) begin
        act_start_o <= pend_start_o;
        act_end_o   <= pend_end_o;
        act_offs_o  <= pend_offs_o;
        act_pgw_o   <= pend_pgw_o;
        act_ctrl_o  <= pend_ctrl_o;
      end
    end
  end

  // Active copy frozen between frame boundaries
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !vsync_i |=> ($stable(act_start_o) && $stable(act_end_o) && $stable(act_offs_o)
                  && $stable(act_pgw_o) && $stable(act_ctrl_o)));

  // Unprotected boundary copies pending and pulses done
  assert_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (vsync_i && !prot_o) |=> (done_o && act_start_o == $past(pend_start_o)
                              && act_ctrl_o == $past(pend_ctrl_o)
                              && act_pgw_o == $past(pend_pgw_o)));

  // Protected boundary leaves active alone
  assert_protect_R5: assert property (@(posedge clk) disable iff (rst)
    (vsync_i && prot_o) |=> (!done_o && $stable(act_start_o) && $stable(act_ctrl_o)));

  // Channel enable only drops at a boundary
  assert_chan_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(act_ctrl_o[1]) |-> $past(vsync_i));
endmodule

// File: rtl/shadow_readback.sv
module shadow_readback
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int OW      = 13,
  parameter int WA      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WA+FIELD_AW-1:0] rd_addr_i,
  input  logic                  rd_active_i,
  input  logic [NUM_WIN*AW-1:0] pend_start_i,
  input  logic [NUM_WIN*AW-1:0] pend_end_i,
  input  logic [NUM_WIN*OW-1:0] pend_offs_i,
  input  logic [NUM_WIN*OW-1:0] pend_pgw_i,
  input  logic [NUM_WIN*2-1:0]  pend_ctrl_i,
  input  logic [NUM_WIN-1:0]    prot_i,
  input  logic [NUM_WIN*AW-1:0] act_start_i,
  input  logic [NUM_WIN*AW-1:0] act_end_i,
  input  logic [NUM_WIN*OW-1:0] act_offs_i,
  input  logic [NUM_WIN*OW-1:0] act_pgw_i,
  input  logic [NUM_WIN*2-1:0]  act_ctrl_i,
  output logic [DW-1:0]         rd_data_o
);
  logic [WA-1:0]       win;
  logic [FIELD_AW-1:0] fld;
  logic [DW-1:0]       nxt;

  assign win = rd_addr_i[FIELD_AW +: WA];
  assign fld = rd_addr_i[FIELD_AW-1:0];

  always_comb begin
    nxt = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win == WA'(w)) begin
        case (fld)
          FLD_START: nxt = rd_active_i ? DW'(act_start_i[w*AW +: AW]) : DW'(pend_start_i[w*AW +: AW]);
          FLD_END:   nxt = rd_active_i ? DW'(act_end_i[w*AW +: AW])   : DW'(pend_end_i[w*AW +: AW]);
          FLD_OFFS:  nxt = rd_active_i ? DW'(act_offs_i[w*OW +: OW])  : DW'(pend_offs_i[w*OW +: OW]);
          FLD_PGW:   nxt = rd_active_i ? DW'(act_pgw_i[w*OW +: OW])   : DW'(pend_pgw_i[w*OW +: OW]);
          FLD_CTRL:  nxt = rd_active_i ? DW'(act_ctrl_i[w*2 +: 2])    : DW'(pend_ctrl_i[w*2 +: 2]);
          FLD_PROT:  nxt = DW'(prot_i[w]);
          default:   nxt = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= nxt;
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int OW      = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [5:0]            wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [5:0]            rd_addr,
  input  logic                  rd_active,
  output logic [DW-1:0]         rd_data,
  input  logic                  vsync,
  output logic [NUM_WIN*AW-1:0] act_start,
  output logic [NUM_WIN*AW-1:0] act_end,
  output logic [NUM_WIN*OW-1:0] act_offs,
  output logic [NUM_WIN*OW-1:0] act_pgw,
  output logic [NUM_WIN-1:0]    act_win_en,
  output logic [NUM_WIN-1:0]    act_chan_en,
  output logic [NUM_WIN-1:0]    xfer_done
);
  localparam int WA = 3;

  logic [WA-1:0]         wr_win;
  logic [FIELD_AW-1:0]   wr_fld;
  logic [NUM_WIN*AW-1:0] pend_start, pend_end;
  logic [NUM_WIN*OW-1:0] pend_offs, pend_pgw;
  logic [NUM_WIN*2-1:0]  pend_ctrl, act_ctrl;
  logic [NUM_WIN-1:0]    prot;

  assign wr_win = wr_addr[FIELD_AW +: WA];
  assign wr_fld = wr_addr[FIELD_AW-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shadow_win #(.DW(DW), .AW(AW), .OW(OW)) u_win (
      .clk          (clk),
      .rst          (rst),
      .wr_en_i      (wr_en && (wr_win == WA'(w))),
      .wr_field_i   (wr_fld),
      .wr_data_i    (wr_data),
      .vsync_i      (vsync),
      .pend_start_o (pend_start[w*AW +: AW]),
      .pend_end_o   (pend_end[w*AW +: AW]),
      .pend_offs_o  (pend_offs[w*OW +: OW]),
      .pend_pgw_o   (pend_pgw[w*OW +: OW]),
      .pend_ctrl_o  (pend_ctrl[w*2 +: 2]),
      .prot_o       (prot[w]),
      .act_start_o  (act_start[w*AW +: AW]),
      .act_end_o    (act_end[w*AW +: AW]),
      .act_offs_o   (act_offs[w*OW +: OW]),
      .act_pgw_o    (act_pgw[w*OW +: OW]),
      .act_ctrl_o   (act_ctrl[w*2 +: 2]),
      .done_o       (xfer_done[w])
    );
    assign act_win_en[w]  = act_ctrl[w*2];
    assign act_chan_en[w] = act_ctrl[w*2+1];
  end

  shadow_readback #(.NUM_WIN(NUM_WIN), .DW(DW), .AW(AW), .OW(OW), .WA(WA)) u_rb (
    .clk          (clk),
    .rst          (rst),
    .rd_addr_i    (rd_addr),
    .rd_active_i  (rd_active),
    .pend_start_i (pend_start),
    .pend_end_i   (pend_end),
    .pend_offs_i  (pend_offs),
    .pend_pgw_i   (pend_pgw),
    .pend_ctrl_i  (pend_ctrl),
    .prot_i       (prot),
    .act_start_i  (act_start),
    .act_end_i    (act_end),
    .act_offs_i   (act_offs),
    .act_pgw_i    (act_pgw),
    .act_ctrl_i   (act_ctrl),
    .rd_data_o    (rd_data)
  );

  // No transfer pulse without a frame boundary
  assert_done_needs_vsync_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_done != '0) |-> $past(vsync));

  // Reset leaves nothing pending on the outputs
  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (xfer_done == '0 && act_chan_en == '0));
endmodule

// File: tb/shadow_bank_tb.sv
module shadow_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic        rd_active = 1'b0;
  logic [31:0] rd_data;
  logic        vsync = 1'b0;
  logic [159:0] act_start, act_end;
  logic [64:0]  act_offs, act_pgw;
  logic [4:0]   act_win_en, act_chan_en, xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  shadow_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(rd_data), .vsync(vsync),
    .act_start(act_start), .act_end(act_end), .act_offs(act_offs), .act_pgw(act_pgw),
    .act_win_en(act_win_en), .act_chan_en(act_chan_en), .xfer_done(xfer_done)
  );

  function automatic logic [5:0] ad(int w, int f);
    return {w[2:0], f[2:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic rd_chk(logic [5:0] a, logic sel, logic [31:0] exp, string req);
    @(negedge clk);
    rd_addr = a; rd_active = sel;
    exp_q.push_back(exp); tag_q.push_back(req);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic vs = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 xfer_done", 32'(xfer_done), 0);
    chk("R1 chan_en", 32'(act_chan_en), 0);
    chk("R1 act_start0", act_start[31:0], 0);
    rd_chk(ad(0,0), 0, 0, "R1 pend start0");
    rd_chk(ad(4,1), 1, 0, "R1 act end4");

    // R2 writes to window 0
    wr(ad(0,0), 32'h1000);
    wr(ad(0,1), 32'h2000);
    wr(ad(0,2), 5);
    wr(ad(0,3), 640);
    wr(ad(0,4), 3);
    rd_chk(ad(0,0), 0, 32'h1000, "R2 pend start0");
    rd_chk(ad(0,3), 0, 640, "R2 pend pgw0");
    rd_chk(ad(0,0), 1, 0, "R9 act start0 before vsync");
    @(negedge clk);
    chk("R3 act_start0 held", act_start[31:0], 0);

    // R4 transfer
    pulse_vsync();
    chk("R4 xfer_done all", 32'(xfer_done), 32'h1f);
    chk("R4 act_start0", act_start[31:0], 32'h1000);
    chk("R4 act_pgw0", 32'(act_pgw[12:0]), 640);
    chk("R4 chan_en0", 32'(act_chan_en), 1);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(xfer_done), 0);
    rd_chk(ad(0,1), 1, 32'h2000, "R9 act end0");

    // R5 / R6 protect
    wr(ad(1,5), 1);
    wr(ad(1,0), 32'hAAAA);
    pulse_vsync();
    chk("R5 done masked", 32'(xfer_done), 32'h1d);
    chk("R5 act_start1 held", act_start[63:32], 0);
    wr(ad(1,5), 0);
    repeat (2) @(negedge clk);
    chk("R3 act_start1 before vsync", act_start[63:32], 0);
    pulse_vsync();
    chk("R6 act_start1", act_start[63:32], 32'hAAAA);

    // R7 channel disable deferred
    wr(ad(0,4), 1);
    repeat (3) @(negedge clk);
    chk("R7 chan still on", 32'(act_chan_en[0]), 1);
    pulse_vsync();
    chk("R7 chan off", 32'(act_chan_en[0]), 0);
    chk("R7 win_en kept", 32'(act_win_en[0]), 1);

    // R8 write during vsync
    wr(ad(2,0), 32'h55, 1'b1);
    chk("R8 act_start2 old", act_start[95:64], 0);
    rd_chk(ad(2,0), 0, 32'h55, "R8 pend start2");
    pulse_vsync();
    chk("R8 act_start2 new", act_start[95:64], 32'h55);

    // R11 protect set on vsync cycle
    wr(ad(3,0), 32'h77);
    wr(ad(3,5), 1, 1'b1);
    chk("R11 transfer before protect", act_start[127:96], 32'h77);
    chk("R11 done3", 32'(xfer_done[3]), 1);
    wr(ad(3,0), 32'h88);
    pulse_vsync();
    chk("R11 protected now", 32'(xfer_done[3]), 0);
    chk("R11 act_start3 held", act_start[127:96], 32'h77);

    // R10 invalid addresses
    wr(ad(6,0), 32'hDEAD);
    wr(ad(0,7), 32'hBEEF);
    wr(ad(0,6), 32'hCAFE);
    rd_chk(ad(6,0), 0, 0, "R10 read bad window");
    rd_chk(ad(0,7), 0, 0, "R10 read bad field");
    rd_chk(ad(0,0), 0, 32'h1000, "R10 pend start0 intact");
    rd_chk(ad(0,1), 0, 32'h2000, "R10 pend end0 intact");
    pulse_vsync();
    chk("R10 act_start0 intact", act_start[31:0], 32'h1000);

    repeat (4) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule